// File: doc/BRIEF.md
# Effective Address Generation Unit

This unit turns a load-register or store-register instruction word into the memory address the instruction refers to. After a start pulse it latches the instruction, reads the selected index register through a read port on an external register file, and adds it to the 20-bit address field. When the instruction's indirect flag is set, the unit then issues one memory read at that sum. The low 20 bits of the word that comes back become the final address. Because the index is added before the pointer fetch, the mode is pre-indexed indirect.

For a load, the unit then reads the operand at the final address and writes it to the destination register in the same cycle as the done pulse. Register zero reads as zero and cannot be written. Selecting it as the index therefore gives plain direct addressing, and a zero address field with a nonzero index gives register-indirect addressing. The memory side is a request pulse with an address, answered by a one-cycle valid strobe after any delay.

Top module: `ea_gen_unit`

## Requirements
- R1: Instruction fields are: opcode in bits 31..27, indirect flag in bit 26, destination register in bits 25..23, index register in bits 22..20, and address field in bits 19..0. Opcode 0x0C is a load. Every other opcode, including the store code 0x0D, is handled as a store.
- R2: With the indirect flag clear, the address reported with done is (address field + index register value) modulo 2^20.
- R3: Index selector 0 contributes zero, whatever value the register file returns for register 0.
- R4: With the indirect flag set, exactly one memory read is issued at the indexed sum, and the reported address is the low 20 bits of the returned word.
- R5: For a load, one further memory read is issued at the final address. In the done cycle, the returned word is written to the destination register.
- R6: A load whose destination is register 0 produces no register write.
- R7: A store writes no register and does not read the operand. A direct store performs no memory read at all.
- R8: Start is accepted only while idle. Busy is high from the cycle after acceptance through the done cycle. Done lasts exactly one cycle. A start pulse while busy has no effect.
- R9: Each memory read is a single-cycle request pulse, and its address is held until the response arrives. The unit waits any number of cycles for the valid strobe and ignores a valid strobe that arrives with no read outstanding.
- R10: During and right after reset, the unit is idle: busy, done, the memory request and the register write are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin computing the address for instr_i |
| instr_i | input | 32 | Instruction word, sampled on acceptance |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion strobe |
| ea_o | output | 20 | Effective address, valid with done_o |
| rf_rd_idx_o | output | 3 | Register file read selector (index register) |
| rf_rd_data_i | input | 32 | Register file read data |
| rf_wr_en_o | output | 1 | Register write strobe (loads only) |
| rf_wr_idx_o | output | 3 | Register write selector |
| rf_wr_data_o | output | 32 | Register write data |
| mem_rd_en_o | output | 1 | Memory read request pulse |
| mem_rd_addr_o | output | 20 | Memory read address |
| mem_rd_valid_i | input | 1 | Memory read response strobe |
| mem_rd_data_i | input | 32 | Memory read response data |

## Verification
Two events can meet in the final cycle of a load: the register write-back and the done strobe. When the destination is also the index register, the same register is both read as an index and then overwritten. The bench gives several loads the same destination and index register and confirms two things: the reported address used the old index value, and the register holds the loaded word afterwards. A start pulse is also driven while an indirect load is waiting for memory, and a stray valid strobe is injected while the unit is idle. In both cases the bench expects exactly one done pulse and unchanged results.

// File: rtl/ea_pkg.sv
package ea_pkg;
    localparam int INSTR_W = 32;
    localparam int DATA_W  = 32;
    localparam int OPC_W   = 5;
    localparam int RIDX_W  = 3;
    localparam int AF_W    = 20;

    // field positions derived from widths (MSB-first layout)
    localparam int AF_LSB  = 0;
    localparam int IDX_LSB = AF_LSB + AF_W;
    localparam int REG_LSB = IDX_LSB + RIDX_W;
    localparam int IND_BIT = REG_LSB + RIDX_W;
    localparam int OPC_LSB = IND_BIT + 1;

    localparam logic [OPC_W-1:0] OPC_LOAD = 5'h0C;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_INDEX_ADD,
        ST_PTR_READ,
        ST_OPERAND_READ,
        ST_DONE
    } ea_state_e;

    typedef struct packed {
        logic              is_load;
        logic              ind;
        logic [RIDX_W-1:0] reg_sel;
        logic [RIDX_W-1:0] idx_sel;
        logic [AF_W-1:0]   afield;
    } ea_dec_t;
endpackage

// File: rtl/ea_instr_decode.sv
module ea_instr_decode
    import ea_pkg::*;
(
    input  logic [INSTR_W-1:0] instr_i,
    output ea_dec_t            dec_o
);
    always_comb begin
        dec_o.is_load = (instr_i[OPC_LSB +: OPC_W] == OPC_LOAD);
        dec_o.ind     = instr_i[IND_BIT];
        dec_o.reg_sel = instr_i[REG_LSB +: RIDX_W];
        dec_o.idx_sel = instr_i[IDX_LSB +: RIDX_W];
        dec_o.afield  = instr_i[AF_LSB +: AF_W];
    end
endmodule

// File: rtl/ea_addr_calc.sv
module ea_addr_calc #(
    parameter int AW = 20,
    parameter int DW = 32,
    parameter int IW = 3
) (
    input  logic [AW-1:0] afield_i,
    input  logic [IW-1:0] idx_sel_i,
    input  logic [DW-1:0] idx_data_i,
    output logic [AW-1:0] sum_o
);
    logic [AW-1:0] idx_val;

    // register zero always contributes zero; no separate direct path
    generate
        if (DW > AW) begin : g_trunc
            logic unused_hi;
            assign unused_hi = ^idx_data_i[DW-1:AW];
            always_comb idx_val = (idx_sel_i == '0) ? '0 : idx_data_i[AW-1:0];
        end else begin : g_ext
            always_comb idx_val = (idx_sel_i == '0) ? '0 : AW'(idx_data_i);
        end
    endgenerate

    // wraps modulo 2^AW
    assign sum_o = afield_i + idx_val;
endmodule

// File: rtl/ea_ctrl.sv
module ea_ctrl
    import ea_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [INSTR_W-1:0] instr_i,
    input  ea_dec_t            dec_i,
    input  logic [AF_W-1:0]    sum_i,
    input  logic               mem_rd_valid_i,
    input  logic [DATA_W-1:0]  mem_rd_data_i,
    output logic               busy_o,
    output logic               done_o,
    output logic [AF_W-1:0]    ea_o,
    output logic [INSTR_W-1:0] instr_q_o,
    output logic               mem_rd_en_o,
    output logic [AF_W-1:0]    mem_rd_addr_o,
    output logic               rf_wr_en_o,
    output logic [RIDX_W-1:0]  rf_wr_idx_o,
    output logic [DATA_W-1:0]  rf_wr_data_o
);
    typedef struct packed {
        ea_state_e          st;
        logic [INSTR_W-1:0] instr;
        logic [AF_W-1:0]    ea;
        logic [DATA_W-1:0]  data;
        logic               pend;
    } ctrl_t;

    localparam ctrl_t CTRL_RST = '{st: ST_IDLE, instr: '0, ea: '0, data: '0, pend: 1'b0};

    ctrl_t q, d;
    logic  rd_req;

    always_comb begin
        d      = q;
        rd_req = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (start_i) begin
                    d.instr = instr_i;
                    d.st    = ST_INDEX_ADD;
                end
            end
            ST_INDEX_ADD: begin
                d.ea = sum_i;
                if (dec_i.ind)          d.st = ST_PTR_READ;
                else if (dec_i.is_load) d.st = ST_OPERAND_READ;
                else                    d.st = ST_DONE;
            end
            ST_PTR_READ: begin
                if (!q.pend) begin
                    rd_req = 1'b1;
                    d.pend = 1'b1;
                end else if (mem_rd_valid_i) begin
                    d.ea   = mem_rd_data_i[AF_W-1:0];
                    d.pend = 1'b0;
                    d.st   = dec_i.is_load ? ST_OPERAND_READ : ST_DONE;
                end
            end
            ST_OPERAND_READ: begin
                if (!q.pend) begin
                    rd_req = 1'b1;
                    d.pend = 1'b1;
                end else if (mem_rd_valid_i) begin
                    d.data = mem_rd_data_i;
                    d.pend = 1'b0;
                    d.st   = ST_DONE;
                end
            end
            ST_DONE: d.st = ST_IDLE;
            default: d = CTRL_RST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= CTRL_RST;
        else        q <= d;
    end

    assign busy_o        = (q.st != ST_IDLE);
    assign done_o        = (q.st == ST_DONE);
    assign ea_o          = q.ea;
    assign instr_q_o     = q.instr;
    assign mem_rd_en_o   = rd_req;
    assign mem_rd_addr_o = q.ea;
    assign rf_wr_en_o    = done_o && dec_i.is_load && (dec_i.reg_sel != '0);
    assign rf_wr_idx_o   = dec_i.reg_sel;
    assign rf_wr_data_o  = q.data;

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R8
    busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_i));
    // R9
    rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en_o |=> !mem_rd_en_o);
    // R9
    rd_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en_o |=> $stable(mem_rd_addr_o));
    // R5
    wr_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rf_wr_en_o |-> done_o);
endmodule

// File: rtl/ea_gen_unit.sv
module ea_gen_unit
    import ea_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [INSTR_W-1:0] instr_i,
    output logic               busy_o,
    output logic               done_o,
    output logic [AF_W-1:0]    ea_o,
    output logic [RIDX_W-1:0]  rf_rd_idx_o,
    input  logic [DATA_W-1:0]  rf_rd_data_i,
    output logic               rf_wr_en_o,
    output logic [RIDX_W-1:0]  rf_wr_idx_o,
    output logic [DATA_W-1:0]  rf_wr_data_o,
    output logic               mem_rd_en_o,
    output logic [AF_W-1:0]    mem_rd_addr_o,
    input  logic               mem_rd_valid_i,
    input  logic [DATA_W-1:0]  mem_rd_data_i
);
    logic [INSTR_W-1:0] instr_q;
    ea_dec_t            dec;
    logic [AF_W-1:0]    sum;

    ea_instr_decode u_dec (
        .instr_i (instr_q),
        .dec_o   (dec)
    );

    ea_addr_calc #(.AW(AF_W), .DW(DATA_W), .IW(RIDX_W)) u_calc (
        .afield_i   (dec.afield),
        .idx_sel_i  (dec.idx_sel),
        .idx_data_i (rf_rd_data_i),
        .sum_o      (sum)
    );

    ea_ctrl u_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .start_i        (start_i),
        .instr_i        (instr_i),
        .dec_i          (dec),
        .sum_i          (sum),
        .mem_rd_valid_i (mem_rd_valid_i),
        .mem_rd_data_i  (mem_rd_data_i),
        .busy_o         (busy_o),
        .done_o         (done_o),
        .ea_o           (ea_o),
        .instr_q_o      (instr_q),
        .mem_rd_en_o    (mem_rd_en_o),
        .mem_rd_addr_o  (mem_rd_addr_o),
        .rf_wr_en_o     (rf_wr_en_o),
        .rf_wr_idx_o    (rf_wr_idx_o),
        .rf_wr_data_o   (rf_wr_data_o)
    );

    assign rf_rd_idx_o = dec.idx_sel;

    // R6
    no_r0_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rf_wr_en_o |-> (rf_wr_idx_o != '0));
    // R7
    direct_store_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !dec.is_load && !dec.ind) |-> !mem_rd_en_o);
    // R7
    store_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !dec.is_load) |-> !rf_wr_en_o);
    // R10
    idle_after_reset_chk: assert property (@(posedge clk)
        $rose(rst_n) |-> (!busy_o && !done_o && !mem_rd_en_o && !rf_wr_en_o));
endmodule

// File: tb/ea_gen_unit_tb.sv
module ea_gen_unit_tb;
    localparam int MDEPTH = 1024;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n, start, busy, done, rf_wr_en, mem_rd_en, mem_rd_valid;
    logic [31:0] instr, rf_rd_data, rf_wr_data, mem_rd_data;
    logic [19:0] ea, mem_rd_addr;
    logic [2:0]  rf_rd_idx, rf_wr_idx;

    ea_gen_unit u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .instr_i(instr),
        .busy_o(busy), .done_o(done), .ea_o(ea),
        .rf_rd_idx_o(rf_rd_idx), .rf_rd_data_i(rf_rd_data),
        .rf_wr_en_o(rf_wr_en), .rf_wr_idx_o(rf_wr_idx), .rf_wr_data_o(rf_wr_data),
        .mem_rd_en_o(mem_rd_en), .mem_rd_addr_o(mem_rd_addr),
        .mem_rd_valid_i(mem_rd_valid), .mem_rd_data_i(mem_rd_data)
    );

    // register file and memory models
    logic [31:0] rf [8];
    logic [31:0] mem [MDEPTH];
    assign rf_rd_data = rf[rf_rd_idx];
    always @(posedge clk) if (rf_wr_en) rf[rf_wr_idx] <= rf_wr_data;

    logic        resp_valid, pending, stray_v;
    logic [31:0] resp_data, stray_d;
    logic [19:0] raddr;
    int          lat_cnt, lat;
    int          rd_cnt = 0, wr_cnt = 0, done_cnt = 0;
    logic [19:0] last_rd_addr;

    assign mem_rd_valid = resp_valid | stray_v;
    assign mem_rd_data  = stray_v ? stray_d : resp_data;

    always @(posedge clk) begin
        resp_valid <= 1'b0;
        if (!rst_n) begin
            pending <= 1'b0;
        end else if (mem_rd_en) begin
            rd_cnt++;
            last_rd_addr <= mem_rd_addr;
            lat = int'($urandom % 3);
            if (lat == 0) begin
                resp_valid <= 1'b1;
                resp_data  <= mem[mem_rd_addr[9:0]];
            end else begin
                pending <= 1'b1;
                raddr   <= mem_rd_addr;
                lat_cnt <= lat - 1;
            end
        end else if (pending) begin
            if (lat_cnt == 0) begin
                resp_valid <= 1'b1;
                resp_data  <= mem[raddr[9:0]];
                pending    <= 1'b0;
            end else begin
                lat_cnt <= lat_cnt - 1;
            end
        end
        if (done)     done_cnt++;
        if (rf_wr_en) wr_cnt++;
    end

    int checks = 0, errors = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic [4:0] opc, input bit ind,
                                       input logic [2:0] dst, input logic [2:0] idx,
                                       input logic [19:0] af);
        return {opc, ind, dst, idx, af};
    endfunction

    task automatic run_op(input logic [31:0] ins, input bit poke);
        logic [4:0]  opc = ins[31:27];
        bit          ind = ins[26];
        logic [2:0]  dst = ins[25:23];
        logic [2:0]  idx = ins[22:20];
        logic [19:0] af  = ins[19:0];
        logic [31:0] idxv = (idx == 0) ? 32'd0 : rf[idx];
        logic [19:0] sum = af + idxv[19:0];
        logic [19:0] xea = ind ? mem[sum[9:0]][19:0] : sum;
        bit          ld  = (opc == 5'h0C);
        logic [31:0] xdata = mem[xea[9:0]];
        int          nrd = int'(ind) + int'(ld);
        bit          wr  = ld && (dst != 0);
        int rd0 = rd_cnt, wr0 = wr_cnt, dn0 = done_cnt;
        logic [31:0] r0 = rf[0];
        int t = 0;
        @(negedge clk); start = 1'b1; instr = ins;
        @(negedge clk); start = 1'b0; instr = $urandom;
        chk(busy, "R8", "busy after accept", 32'(busy), 1);
        while (!done && t < 60) begin
            start = (poke && t == 1);
            @(negedge clk);
            t++;
        end
        start = 1'b0;
        chk(done, "R8", "done strobe seen", 32'(done), 1);
        chk(ea == xea, ind ? "R4" : "R2", "effective address", 32'(ea), 32'(xea));
        chk(rf_wr_en == wr, ld ? "R5" : "R7", "write strobe at done", 32'(rf_wr_en), 32'(wr));
        if (wr) chk(rf_wr_data == xdata, "R5", "write data", rf_wr_data, xdata);
        @(negedge clk);
        chk(!done && !busy, "R8", "idle after done", {busy, done}, 0);
        chk(done_cnt - dn0 == 1, "R8", "done pulse count", 32'(done_cnt - dn0), 1);
        chk(rd_cnt - rd0 == nrd, ld ? "R5" : "R7", "memory read count", 32'(rd_cnt - rd0), 32'(nrd));
        if (nrd > 0)
            chk(last_rd_addr == (ld ? xea : sum), "R9", "last read address",
                32'(last_rd_addr), 32'(ld ? xea : sum));
        chk(wr_cnt - wr0 == int'(wr), "R6", "register write count", 32'(wr_cnt - wr0), 32'(wr));
        if (wr) chk(rf[dst] == xdata, "R5", "destination contents", rf[dst], xdata);
        chk(rf[0] == r0, "R6", "register zero untouched", rf[0], r0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1234ABCD));
        rst_n = 1'b0; start = 1'b0; instr = '0; stray_v = 1'b0; stray_d = '0;
        for (int i = 0; i < MDEPTH; i++) mem[i] = $urandom;
        for (int i = 0; i < 8; i++) rf[i] = $urandom;
        repeat (3) @(negedge clk);
        chk(!busy && !done && !mem_rd_en && !rf_wr_en, "R10", "outputs in reset",
            {busy, done, mem_rd_en, rf_wr_en}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !mem_rd_en && !rf_wr_en, "R10", "outputs after reset",
            {busy, done, mem_rd_en, rf_wr_en}, 0);

        // R1 R2 indexed load vector
        rf[3] = 32'd4; mem[20'h0E] = 32'hF;
        run_op(mk(5'h0C, 0, 3'd1, 3'd3, 20'h0000A), 0);
        chk(rf[1] == 32'hF, "R2", "indexed load value", rf[1], 32'hF);

        // R4 pre-indexed indirect vector
        rf[3] = 32'd7; mem[20'h11] = 32'h08; mem[20'h08] = 32'h1E;
        run_op(mk(5'h0C, 1, 3'd1, 3'd3, 20'h0000A), 0);
        chk(rf[1] == 32'h1E, "R4", "indirect load value", rf[1], 32'h1E);

        // R3 index zero ignores register file contents
        rf[0] = 32'h0000_0ABC;
        run_op(mk(5'h0D, 0, 3'd2, 3'd0, 20'h00123), 0);
        chk(ea == 20'h00123, "R3", "direct via register zero", 32'(ea), 32'h123);

        // R4 register-indirect with high pointer bits dropped
        rf[5] = 32'h200; mem[20'h200] = 32'hABC0_0012;
        run_op(mk(5'h0C, 1, 3'd2, 3'd5, 20'h00000), 0);
        chk(ea == 20'h00012, "R4", "pointer low bits", 32'(ea), 32'h12);

        // R2 wrap modulo 2^20
        rf[6] = 32'd3;
        run_op(mk(5'h0D, 0, 3'd1, 3'd6, 20'hFFFFF), 0);
        chk(ea == 20'h00002, "R2", "address wrap", 32'(ea), 32'h2);

        // R6 load into register zero
        run_op(mk(5'h0C, 1, 3'd0, 3'd3, 20'h0000A), 0);
        // R1 R7 unknown opcode acts as store
        run_op(mk(5'h1F, 1, 3'd4, 3'd3, 20'h0000A), 0);
        // R5 destination equals index register
        rf[4] = 32'h30;
        run_op(mk(5'h0C, 0, 3'd4, 3'd4, 20'h00010), 0);
        // R8 start pulse while busy
        run_op(mk(5'h0C, 1, 3'd7, 3'd3, 20'h0000A), 1);

        // R9 stray valid while idle is ignored
        @(negedge clk); stray_v = 1'b1; stray_d = 32'hFFFF_FFFF;
        @(negedge clk); stray_v = 1'b0;
        chk(!busy && !done, "R9", "stray valid ignored", {busy, done}, 0);
        run_op(mk(5'h0C, 1, 3'd2, 3'd3, 20'h0000A), 0);

        for (int n = 0; n < 200; n++) begin
            logic [4:0] opc;
            int sel = int'($urandom % 3);
            opc = (sel == 0) ? 5'h0C : (sel == 1) ? 5'h0D : 5'(($urandom % 32));
            if ($urandom % 4 == 0) rf[$urandom % 8] = $urandom;
            run_op(mk(opc, 1'($urandom), 3'($urandom), 3'($urandom), 20'($urandom)),
                   ($urandom % 5 == 0));
        end

        finished = 1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule